// File: doc/BRIEF.md
# Lockstep Checkpoint-Retry Recovery Controller

This block supervises a duplicated execution pair that runs one instruction stream in lockstep, plus one spare copy held in reserve. Whenever either copy signals that it has finished an instruction, the controller compares the two full state vectors. A clean match is latched as the last known-good checkpoint. Any disagreement raises a machine-check pulse and starts recovery.

Recovery has two stages. On the first disagreement the pair is rolled back to the checkpoint and the instruction runs once more. If that second attempt agrees, execution resumes and a saturating soft-error count goes up by one. If it disagrees again, the checkpoint is loaded into both the surviving unit A and the spare. The spare then takes unit B's place in the comparison, and B is marked bad for good. A hard failure after the spare has been used stops the machine: all units are held and a fatal flag stays set until reset.

The execution units sit outside the block. They take the checkpoint vector when told to restore or load, and they present their state with a done strobe.

Top module: `lockstep_recovery`

## Requirements
- R1: After a synchronous reset, the checkpoint output holds the parameter CKPT_INIT, all status flags and strobes are 0, and the soft-error count is 0.
- R2: When both compared units assert done in the same cycle with equal state, the checkpoint output shows that state from the next cycle, and no machine check is raised.
- R3: A mismatch produces a machine-check pulse exactly one cycle long, in the cycle after the mismatch was sampled. A mismatch is either a done strobe from only one compared unit, or both strobes with differing state.
- R4: A mismatch during normal running asserts restore_o for exactly one cycle, together with the machine check. The checkpoint does not change in that cycle, and done strobes arriving in that cycle are ignored.
- R5: After a restore, the next compared completion is the retry. If it matches, the checkpoint updates, the soft-error count rises by 1, and normal running resumes.
- R6: The soft-error count saturates at 2^SOFT_W-1 and never wraps.
- R7: A failed retry while the spare is unused asserts spare_load_o and restore_o together for one cycle. In that same cycle, spare_active_o and b_bad_o are set, and both stay set until reset. From then on the spare's state and done strobe replace unit B's, and unit B's inputs have no effect.
- R8: A failed retry after the spare is in use sets fatal_o permanently until reset. After that, no machine check, restore or spare load is issued.
- R9: hold_o is high in the restore cycle, in the spare-load cycle and throughout the stopped state, and low otherwise.
- R10: A restore issued before any good completion presents CKPT_INIT on the checkpoint output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_state | input | W | Unit A architectural state |
| a_done | input | 1 | Unit A instruction complete |
| b_state | input | W | Unit B architectural state |
| b_done | input | 1 | Unit B instruction complete |
| s_state | input | W | Spare unit architectural state |
| s_done | input | 1 | Spare unit instruction complete |
| ckpt_o | output | W | Last known-good state, used as restore/load data |
| restore_o | output | 1 | Compared units load ckpt_o this cycle |
| spare_load_o | output | 1 | Spare loads ckpt_o and starts |
| spare_active_o | output | 1 | Spare has replaced unit B |
| b_bad_o | output | 1 | Unit B retired (sticky) |
| hold_o | output | 1 | Units must not advance |
| mcheck_o | output | 1 | Machine-check pulse per mismatch |
| fatal_o | output | 1 | Permanent stop, second hard failure |
| soft_cnt_o | output | SOFT_W | Saturating count of recovered errors |

## Verification
A wrong internal state shows up at the ports within one cycle of the next completion event. A controller stuck in the wrong recovery phase either pulses restore_o where spare_load_o was due, or misses the soft-error increment when the retry succeeds. A bad partner selection shows up as machine checks while unit B carries garbage after the swap, or as missed checks while the spare disagrees. A checkpoint corrupted during recovery appears directly on ckpt_o at the next restore. The bench drives the same completion events into a port-level model and compares every output after every clock.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_RESTORE,
    ST_RETRY,
    ST_SPARE_LOAD,
    ST_CHECKSTOP
  } ls_state_e;
endpackage

// File: rtl/lockstep_cmp.sv
// Completion comparator: classifies a cycle as match, mismatch or idle.
module lockstep_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_state,
  input  logic         x_done,
  input  logic [W-1:0] y_state,
  input  logic         y_done,
  output logic         match_o,
  output logic         miss_o
);
  logic both, any, same;
  assign both    = x_done & y_done;
  assign any     = x_done | y_done;
  assign same    = (x_state == y_state);
  assign match_o = both & same;
  assign miss_o  = any & ~(both & same);
endmodule

// File: rtl/lockstep_ckpt.sv
// Last known-good state register with a defined reset image.
module lockstep_ckpt #(
  parameter int          W    = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= INIT;
    else if (we) q <= d;
  end
endmodule

// File: rtl/lockstep_fsm.sv
// Recovery sequencer: retry once in place, then swap in the spare, then stop.
module lockstep_fsm
  import lockstep_pkg::*;
#(
  parameter int SOFT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              match_i,
  input  logic              miss_i,
  output logic              ckpt_we_o,
  output logic              restore_o,
  output logic              spare_load_o,
  output logic              spare_active_o,
  output logic              hold_o,
  output logic              mcheck_o,
  output logic              fatal_o,
  output logic [SOFT_W-1:0] soft_cnt_o
);
  localparam logic [SOFT_W-1:0] SOFT_MAX = '1;

  ls_state_e st_q, st_d;
  logic      live;

  assign live      = (st_q == ST_RUN) || (st_q == ST_RETRY);
  assign ckpt_we_o = live && match_i;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:        if (miss_i) st_d = ST_RESTORE;
      ST_RESTORE:    st_d = ST_RETRY;
      ST_RETRY: begin
        if (match_i)     st_d = ST_RUN;
        else if (miss_i) st_d = spare_active_o ? ST_CHECKSTOP : ST_SPARE_LOAD;
      end
      ST_SPARE_LOAD: st_d = ST_RUN;
      default:       st_d = ST_CHECKSTOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_RUN;
      mcheck_o       <= 1'b0;
      restore_o      <= 1'b0;
      spare_load_o   <= 1'b0;
      spare_active_o <= 1'b0;
      hold_o         <= 1'b0;
      fatal_o        <= 1'b0;
      soft_cnt_o     <= '0;
    end else begin
      st_q         <= st_d;
      mcheck_o     <= live && miss_i;
      restore_o    <= (st_d == ST_RESTORE) || (st_d == ST_SPARE_LOAD);
      spare_load_o <= (st_d == ST_SPARE_LOAD);
      hold_o       <= (st_d == ST_RESTORE) || (st_d == ST_SPARE_LOAD) ||
                      (st_d == ST_CHECKSTOP);
      fatal_o      <= (st_d == ST_CHECKSTOP);
      if (st_d == ST_SPARE_LOAD) spare_active_o <= 1'b1;
      if (st_q == ST_RETRY && match_i && soft_cnt_o != SOFT_MAX)
        soft_cnt_o <= soft_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/lockstep_recovery.sv
module lockstep_recovery #(
  parameter int           W      = 32,
  parameter int           SOFT_W = 4,
  parameter logic [W-1:0] CKPT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      a_state,
  input  logic              a_done,
  input  logic [W-1:0]      b_state,
  input  logic              b_done,
  input  logic [W-1:0]      s_state,
  input  logic              s_done,
  output logic [W-1:0]      ckpt_o,
  output logic              restore_o,
  output logic              spare_load_o,
  output logic              spare_active_o,
  output logic              b_bad_o,
  output logic              hold_o,
  output logic              mcheck_o,
  output logic              fatal_o,
  output logic [SOFT_W-1:0] soft_cnt_o
);
  logic [W-1:0] p_state;
  logic         p_done, match, miss, ckpt_we;

  // Partner of unit A: B until the swap, spare afterwards.
  assign p_state = spare_active_o ? s_state : b_state;
  assign p_done  = spare_active_o ? s_done  : b_done;
  assign b_bad_o = spare_active_o;

  lockstep_cmp #(.W(W)) u_cmp (
    .x_state(a_state), .x_done(a_done),
    .y_state(p_state), .y_done(p_done),
    .match_o(match),   .miss_o(miss)
  );

  lockstep_ckpt #(.W(W), .INIT(CKPT_INIT)) u_ckpt (
    .clk(clk), .rst(rst), .we(ckpt_we), .d(a_state), .q(ckpt_o)
  );

  lockstep_fsm #(.SOFT_W(SOFT_W)) u_fsm (
    .clk(clk), .rst(rst), .match_i(match), .miss_i(miss),
    .ckpt_we_o(ckpt_we), .restore_o(restore_o), .spare_load_o(spare_load_o),
    .spare_active_o(spare_active_o), .hold_o(hold_o), .mcheck_o(mcheck_o),
    .fatal_o(fatal_o), .soft_cnt_o(soft_cnt_o)
  );
endmodule

// File: rtl/lockstep_recovery_chk.sv
module lockstep_recovery_chk #(
  parameter int W      = 32,
  parameter int SOFT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [W-1:0]      ckpt_o,
  input logic              restore_o,
  input logic              spare_load_o,
  input logic              spare_active_o,
  input logic              b_bad_o,
  input logic              hold_o,
  input logic              mcheck_o,
  input logic              fatal_o,
  input logic [SOFT_W-1:0] soft_cnt_o
);
  assert_mcheck_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    mcheck_o |=> !mcheck_o);
  assert_restore_with_check_R4: assert property (@(posedge clk) disable iff (rst)
    (mcheck_o && !fatal_o) |-> restore_o);
  assert_restore_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    restore_o |=> !restore_o);
  assert_ckpt_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    restore_o |=> $stable(ckpt_o));
  assert_soft_step_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(soft_cnt_o) |-> (soft_cnt_o == $past(soft_cnt_o) + 1'b1));
  assert_soft_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (&soft_cnt_o) |=> (&soft_cnt_o));
  assert_spare_flags_R7: assert property (@(posedge clk) disable iff (rst)
    spare_load_o |-> (spare_active_o && b_bad_o && restore_o));
  assert_spare_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    spare_active_o |=> (spare_active_o && b_bad_o));
  assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fatal_o |=> (fatal_o && !restore_o && !spare_load_o && !mcheck_o));
  assert_hold_cover_R9: assert property (@(posedge clk) disable iff (rst)
    (fatal_o || restore_o) |-> hold_o);
endmodule

bind lockstep_recovery lockstep_recovery_chk #(.W(W), .SOFT_W(SOFT_W)) u_chk (
  .clk(clk), .rst(rst), .ckpt_o(ckpt_o), .restore_o(restore_o),
  .spare_load_o(spare_load_o), .spare_active_o(spare_active_o),
  .b_bad_o(b_bad_o), .hold_o(hold_o), .mcheck_o(mcheck_o),
  .fatal_o(fatal_o), .soft_cnt_o(soft_cnt_o)
);

// File: tb/lockstep_recovery_test.sv
module lockstep_recovery_test;
  localparam int           W      = 32;
  localparam int           SOFT_W = 4;
  localparam logic [W-1:0] INIT   = 32'hC0DE_0001;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [W-1:0]      a_state = '0, b_state = '0, s_state = '0;
  logic              a_done = 1'b0, b_done = 1'b0, s_done = 1'b0;
  logic [W-1:0]      ckpt_o;
  logic              restore_o, spare_load_o, spare_active_o, b_bad_o;
  logic              hold_o, mcheck_o, fatal_o;
  logic [SOFT_W-1:0] soft_cnt_o;

  int n_tests = 0, n_fail = 0;

  // Port-level model: 0 run, 1 restore, 2 retry, 3 spare load, 4 stopped
  int           m_ph;
  logic [W-1:0] m_ckpt;
  logic         m_spare, m_mc, m_rs, m_sl;
  int           m_soft;

  lockstep_recovery #(.W(W), .SOFT_W(SOFT_W), .CKPT_INIT(INIT)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int sat_inc(input int v);
    return (v == (1 << SOFT_W) - 1) ? v : v + 1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_done = 0; b_done = 0; s_done = 0;
    repeat (3) @(posedge clk);
    #1;
    m_ph = 0; m_ckpt = INIT; m_spare = 0; m_mc = 0; m_rs = 0; m_sl = 0; m_soft = 0;
    chk("R1 ckpt", ckpt_o, INIT);
    chk("R1 flags", {restore_o, spare_load_o, spare_active_o, b_bad_o, hold_o, mcheck_o, fatal_o}, 0);
    chk("R1 soft", soft_cnt_o, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input logic [W-1:0] a, input logic ad, input logic [W-1:0] b,
                      input logic bd, input logic [W-1:0] s, input logic sd);
    logic [W-1:0] p;
    logic pd, mt, ms;
    @(negedge clk);
    a_state = a; a_done = ad; b_state = b; b_done = bd; s_state = s; s_done = sd;
    p  = m_spare ? s : b;
    pd = m_spare ? sd : bd;
    mt = ad & pd & (a == p);
    ms = (ad | pd) & ~mt;
    m_mc = 0; m_rs = 0; m_sl = 0;
    case (m_ph)
      0: if (mt) m_ckpt = a; else if (ms) begin m_mc = 1; m_rs = 1; m_ph = 1; end
      1: m_ph = 2;
      2: if (mt) begin m_ckpt = a; m_soft = sat_inc(m_soft); m_ph = 0; end
         else if (ms) begin
           m_mc = 1;
           if (!m_spare) begin m_rs = 1; m_sl = 1; m_spare = 1; m_ph = 3; end
           else m_ph = 4;
         end
      3: m_ph = 0;
      default: m_ph = 4;
    endcase
    @(posedge clk);
    #1;
    chk("R2 ckpt", ckpt_o, m_ckpt);
    chk("R3 mcheck", mcheck_o, m_mc);
    chk("R4 restore", restore_o, m_rs);
    chk("R5 soft", soft_cnt_o, m_soft);
    chk("R7 spare", {spare_load_o, spare_active_o, b_bad_o}, {m_sl, m_spare, m_spare});
    chk("R8 fatal", fatal_o, m_ph == 4);
    chk("R9 hold", hold_o, (m_ph == 1) || (m_ph == 3) || (m_ph == 4));
  endtask

  task automatic idle();
    step('0, 0, '0, 0, '0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R10: restore before any good completion shows the reset image
    step(32'h11, 1, 32'h22, 1, 0, 0);
    chk("R10 restore", restore_o, 1);
    chk("R10 ckpt", ckpt_o, INIT);
    // R4: strobes in the restore cycle are ignored
    step(32'h77, 1, 32'h78, 1, 0, 0);
    step(32'h99, 1, 32'h99, 1, 0, 0);       // R5 retry good
    step(32'h100, 1, 32'h100, 1, 0, 0);     // R2 plain match
    step(32'h5, 1, 32'h5, 0, 0, 0);         // R3 single strobe
    idle();
    step(32'h6, 0, 32'h6, 1, 0, 0);         // retry with only B done: fails
    idle();                                 // spare-load cycle
    // R7: B garbage ignored, spare partners with A
    step(32'h7, 1, 32'hDEAD, 1, 32'h7, 1);
    chk("R7 b ignored", {mcheck_o, ckpt_o}, {1'b0, 32'h7});
    // R6: drive many soft errors to saturation
    for (int i = 0; i < 20; i++) begin
      step(i, 1, 0, 0, i + 1, 1);
      idle();
      step(i, 1, 0, 0, i, 1);
    end
    chk("R6 saturate", soft_cnt_o, (1 << SOFT_W) - 1);
    // R8: second hard failure stops the machine
    step(1, 1, 0, 0, 2, 1);
    idle();
    step(3, 1, 0, 0, 4, 1);
    for (int i = 0; i < 6; i++) step(i, 1, 0, 0, i + 9, 1);
    chk("R8 stopped", {fatal_o, hold_o, mcheck_o}, 3'b110);

    // Random phase with occasional resets
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int k = 0; k < 2500; k++) begin
        logic [W-1:0] a, b, s;
        logic ad, bd, sd;
        int sel;
        sel = $urandom_range(0, 99);
        a = $urandom; b = $urandom; s = $urandom;
        ad = 1; bd = 1; sd = 1;
        if (sel < 75) begin b = a; s = a; end
        else if (sel < 85) begin end
        else if (sel < 92) begin b = a; s = a; bd = $urandom_range(0, 1); sd = ~bd; ad = ~bd; end
        else begin ad = 0; bd = 0; sd = 0; end
        step(a, ad, b, bd, s, sd);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule